// File: doc/BRIEF.md
# Masked ALU Flag Generator

This unit produces the status flag word that follows an ALU micro-operation. It takes the flag word as it stood before the operation, a per-bit update mask, the operation's two source operands and result, an operand-size code and a subtract indicator. The unit recomputes only the flags the mask selects and copies every other bit unchanged from the old word. The result is captured into an output register on a valid strobe.

The flag word holds eight bits: carry, parity, auxiliary (nibble) carry, zero, sign and overflow, plus a second carry and a second zero used only by emulation sequences. The second carry never takes the borrow inversion that the primary carry and the auxiliary carry take on a subtract. The caller presents the effective addend on `src2`. For a subtract this is the bit-inverted subtrahend, and the carry-in of one is implied by `subtract`.

Top module: `alu_flag_gen`

## Requirements
- R1: A flag bit whose `flagMask` bit is 0 takes the value of the same bit of `oldFlags`. A bit whose mask bit is 1 is recomputed and does not depend on its old value.
- R2: Carry (bit 0) is the carry out of the most significant bit at the operand width, computed from `src1`, `src2` and `dest`. When `subtract` is 1 it is inverted, so that it reads as a borrow.
- R3: Auxiliary carry (bit 2) is the carry out of bit 3 into bit 4. It is inverted when `subtract` is 1.
- R4: Emulation carry (bit 6) is the same carry out as in R2, and it is never inverted.
- R5: Zero (bit 3) and emulation zero (bit 7) are both 1 exactly when `dest`, truncated to the operand width, is zero. Result bits above the width are ignored.
- R6: Parity (bit 1) is 1 when the low 8 bits of `dest` hold an even number of ones.
- R7: Sign (bit 4) equals the `dest` bit at position width-1.
- R8: Overflow (bit 5) is 1 when `src1` and `src2` have the same sign at the operand width and the sign of `dest` differs from it.
- R9: When `valid` is high on a rising clock edge, `flagsOut` shows the new word after that edge. While `valid` is low, `flagsOut` holds its value.
- R10: When `rst` is high on a rising edge, `flagsOut` is cleared to zero. Reset takes priority over `valid`.
- R11: `sizeSel` selects the operand width: 0 selects 8 bits, 1 selects 16 bits, 2 selects 32 bits and 3 selects 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid | input | 1 | Capture strobe for a new flag word |
| sizeSel | input | 2 | Operand-size code |
| subtract | input | 1 | Operation is a subtract |
| flagMask | input | 8 | Selects the flags to recompute |
| oldFlags | input | 8 | Flag word before the operation |
| src1 | input | DATA_W | First source operand |
| src2 | input | DATA_W | Effective addend |
| dest | input | DATA_W | Operation result |
| flagsOut | output | 8 | Registered flag word |

## Verification
The only state in the block is the output register, so any fault in it, or in the flag logic that feeds it, appears at `flagsOut` on the edge after the `valid` that captured it. A wrong width decode shows up as a wrong sign, zero or overflow bit at one size code. A lost subtract inversion shows up as carry and emulation carry agreeing when they should differ. A register that fails to hold shows up as `flagsOut` changing in a cycle with `valid` low.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int FLAG_W    = 8;
  localparam int NUM_SIZES = 4;
  localparam int SIZE_W    = $clog2(NUM_SIZES);

  // Flag word layout
  localparam int CF_POS  = 0;
  localparam int PF_POS  = 1;
  localparam int AF_POS  = 2;
  localparam int ZF_POS  = 3;
  localparam int SF_POS  = 4;
  localparam int OF_POS  = 5;
  localparam int ECF_POS = 6;
  localparam int EZF_POS = 7;

  typedef struct packed {
    logic                 load;
    logic                 clear;
    logic [NUM_SIZES-1:0] widthSel;
  } flag_ctrl_t;
endpackage

// File: rtl/alu_flag_ctrl.sv
module alu_flag_ctrl
  import alu_flag_pkg::*;
(
  input  logic              rst,
  input  logic              valid,
  input  logic [SIZE_W-1:0] sizeSel,
  output flag_ctrl_t        ctrl
);
  always_comb begin
    ctrl.clear    = rst;
    ctrl.load     = valid & ~rst;   // R10: reset wins over valid
    ctrl.widthSel = '0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      ctrl.widthSel[i] = (sizeSel == SIZE_W'(i)); // R11 size decode
    end
  end
endmodule

// File: rtl/alu_flag_dp.sv
module alu_flag_dp
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  flag_ctrl_t        ctrl,
  input  logic              subtract,
  input  logic [FLAG_W-1:0] flagMask,
  input  logic [FLAG_W-1:0] oldFlags,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [DATA_W-1:0] dest,
  output logic [FLAG_W-1:0] flagsOut
);
  logic [NUM_SIZES-1:0] carryW, zeroW, signW, ovfW;

  // One flag slice per supported operand width
  for (genvar i = 0; i < NUM_SIZES; i++) begin : g_width
    localparam int W = 8 << i;
    if (W <= DATA_W) begin : g_on
      logic aTop, bTop, dTop;
      assign aTop = src1[W-1];
      assign bTop = src2[W-1];
      assign dTop = dest[W-1];
      assign carryW[i] = (aTop & bTop) | ((aTop | bTop) & ~dTop);
      assign zeroW[i]  = (dest[W-1:0] == '0);
      assign signW[i]  = dTop;
      assign ovfW[i]   = (aTop ~^ bTop) & (dTop ^ aTop);
    end else begin : g_off
      assign carryW[i] = 1'b0;
      assign zeroW[i]  = 1'b0;
      assign signW[i]  = 1'b0;
      assign ovfW[i]   = 1'b0;
    end
  end

  logic carrySel, zeroSel, signSel, ovfSel, nibCarry, parityEven;
  logic [FLAG_W-1:0] fresh, nextFlags;

  always_comb begin
    carrySel = 1'b0;
    zeroSel  = 1'b0;
    signSel  = 1'b0;
    ovfSel   = 1'b0;
    for (int i = 0; i < NUM_SIZES; i++) begin
      carrySel |= ctrl.widthSel[i] & carryW[i];
      zeroSel  |= ctrl.widthSel[i] & zeroW[i];
      signSel  |= ctrl.widthSel[i] & signW[i];
      ovfSel   |= ctrl.widthSel[i] & ovfW[i];
    end
    nibCarry   = src1[4] ^ src2[4] ^ dest[4];
    parityEven = ~^dest[7:0];

    fresh          = '0;
    fresh[CF_POS]  = carrySel ^ subtract;
    fresh[PF_POS]  = parityEven;
    fresh[AF_POS]  = nibCarry ^ subtract;
    fresh[ZF_POS]  = zeroSel;
    fresh[SF_POS]  = signSel;
    fresh[OF_POS]  = ovfSel;
    fresh[ECF_POS] = carrySel;
    fresh[EZF_POS] = zeroSel;

    nextFlags = (oldFlags & ~flagMask) | (fresh & flagMask);
  end

  always_ff @(posedge clk) begin
    if (ctrl.clear)     flagsOut <= '0;
    else if (ctrl.load) flagsOut <= nextFlags;
  end

  // R1: unmasked bits come straight from the old word
  a_r1_unmasked_hold: assert property (@(posedge clk) disable iff (ctrl.clear)
    ctrl.load |=> (((flagsOut ^ $past(oldFlags)) & ~$past(flagMask)) == '0));

  // R9: no strobe, no change
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (ctrl.clear)
    !ctrl.load |=> $stable(flagsOut));

  // R4: emulation carry tracks carry on an add
  a_r4_ecf_add: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.load && !subtract && flagMask[CF_POS] && flagMask[ECF_POS])
      |=> (flagsOut[CF_POS] == flagsOut[ECF_POS]));

  // R2: on a subtract carry is the inverse of emulation carry
  a_r2_borrow_invert: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.load && subtract && flagMask[CF_POS] && flagMask[ECF_POS])
      |=> (flagsOut[CF_POS] != flagsOut[ECF_POS]));

  // R5: both zero flags agree
  a_r5_zero_pair: assert property (@(posedge clk) disable iff (ctrl.clear)
    (ctrl.load && flagMask[ZF_POS] && flagMask[EZF_POS])
      |=> (flagsOut[ZF_POS] == flagsOut[EZF_POS]));

  // R10: reset clears the word
  a_r10_reset_clear: assert property (@(posedge clk)
    ctrl.clear |=> (flagsOut == '0));
endmodule

// File: rtl/alu_flag_gen.sv
module alu_flag_gen
  import alu_flag_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              valid,
  input  logic [1:0]        sizeSel,
  input  logic              subtract,
  input  logic [7:0]        flagMask,
  input  logic [7:0]        oldFlags,
  input  logic [DATA_W-1:0] src1,
  input  logic [DATA_W-1:0] src2,
  input  logic [DATA_W-1:0] dest,
  output logic [7:0]        flagsOut
);
  flag_ctrl_t ctrl;

  alu_flag_ctrl ctrl_i (
    .rst     (rst),
    .valid   (valid),
    .sizeSel (sizeSel),
    .ctrl    (ctrl)
  );

  alu_flag_dp #(.DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .ctrl     (ctrl),
    .subtract (subtract),
    .flagMask (flagMask),
    .oldFlags (oldFlags),
    .src1     (src1),
    .src2     (src2),
    .dest     (dest),
    .flagsOut (flagsOut)
  );
endmodule

// File: tb/alu_flag_gen_tb_top.sv
`timescale 1ns/1ps
module alu_flag_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        valid = 1'b0;
  logic [1:0]  sizeSel = '0;
  logic        subtract = 1'b0;
  logic [7:0]  flagMask = '0;
  logic [7:0]  oldFlags = '0;
  logic [63:0] src1 = '0, src2 = '0, dest = '0;
  logic [7:0]  flagsOut;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  logic [7:0] expWord;

  always #4 clk = ~clk;

  alu_flag_gen #(.DATA_W(64)) dut_i (
    .clk(clk), .rst(rst), .valid(valid), .sizeSel(sizeSel),
    .subtract(subtract), .flagMask(flagMask), .oldFlags(oldFlags),
    .src1(src1), .src2(src2), .dest(dest), .flagsOut(flagsOut)
  );

  // Requirement owning each bit position: CF PF AF ZF SF OF ECF EZF
  string bitReq [8] = '{"R2", "R6", "R3", "R5", "R7", "R8", "R4", "R5"};

  task automatic chkWord(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s flagsOut act=%02h exp=%02h", tag, act, exp);
    end
  endtask

  task automatic chkBits(logic [7:0] act, logic [7:0] exp);
    for (int b = 0; b < 8; b++) begin
      checks++;
      if (act[b] !== exp[b]) begin
        failures++;
        $display("FAIL %s bit%0d act=%0b exp=%0b (word act=%02h exp=%02h)",
                 bitReq[b], b, act[b], exp[b], act, exp);
      end
    end
  endtask

  // Builds dest from the operands, drives one operation and computes the
  // expected word from width arithmetic.
  task automatic runOp(logic [7:0] oldF, logic [7:0] msk, logic [63:0] a,
                       logic [63:0] bRaw, logic [1:0] sz, logic sub,
                       logic [63:0] junk);
    int n;
    logic [63:0] m, bEff, d;
    logic [64:0] full;
    logic [4:0]  nib;
    logic carry, aux, zero, ovf;
    logic [7:0] fresh;
    n    = 8 << sz;
    m    = (n == 64) ? '1 : ((64'd1 << n) - 64'd1);
    bEff = sub ? ~bRaw : bRaw;
    full = {1'b0, a & m} + {1'b0, bEff & m} + {64'd0, sub};
    d    = (full[63:0] & m) | (junk & ~m);
    carry = full[n];
    nib   = {1'b0, a[3:0]} + {1'b0, bEff[3:0]} + {4'd0, sub};
    aux   = nib[4];
    zero  = ((d & m) == 0);
    ovf   = (a[n-1] == bEff[n-1]) && (d[n-1] != a[n-1]);
    fresh = {zero, carry, ovf, d[n-1], zero, aux ^ sub,
             ($countones(d[7:0]) % 2 == 0), carry ^ sub};
    expWord = (oldF & ~msk) | (fresh & msk);
    @(negedge clk);
    valid = 1'b1; oldFlags = oldF; flagMask = msk; src1 = a; src2 = bEff;
    dest = d; sizeSel = sz; subtract = sub;
    @(negedge clk);
    valid = 1'b0;
  endtask

  initial begin
    #(8ns * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R10: reset state
    chkWord("R10 reset", flagsOut, 8'h00);
    rst = 1'b0;

    // R1: empty mask copies old word
    runOp(8'hA5, 8'h00, 64'h12, 64'h34, 2'd0, 1'b0, '0);
    chkWord("R1 mask empty", flagsOut, 8'hA5);

    // R2 R4: a - a -> no borrow, emulation carry set
    runOp(8'h00, 8'hFF, 64'h55, 64'h55, 2'd0, 1'b1, '0);
    chkBits(flagsOut, expWord);
    chkWord("R2 R4 equal subtract", flagsOut & 8'h41, 8'h40);

    // R2: 0 - 1 borrows
    runOp(8'h00, 8'hFF, 64'h0, 64'h1, 2'd1, 1'b1, '0);
    chkWord("R2 borrow", flagsOut & 8'h41, 8'h01);

    // R8 R3: 0x7F + 1 at byte width
    runOp(8'h00, 8'hFF, 64'h7F, 64'h1, 2'd0, 1'b0, '0);
    chkWord("R8 R3 byte overflow", flagsOut & 8'h24, 8'h24);

    // R5: zero result at 16 bits with junk above the width
    runOp(8'h00, 8'hFF, 64'hFFFF, 64'h1, 2'd1, 1'b0, 64'hDEAD_BEEF_0000_0000);
    chkWord("R5 truncated zero", flagsOut & 8'h88, 8'h88);

    // R11 R7: same operands at each size, sign follows the width
    for (int s = 0; s < 4; s++) begin
      runOp(8'h00, 8'hFF, 64'h4000_0000_4000_4040, 64'h4000_0000_4000_4040,
            2'(s), 1'b0, '0);
      chkWord("R11 size select", flagsOut, expWord);
    end

    // R9: idle cycles hold while inputs change
    for (int k = 0; k < 4; k++) begin
      logic [7:0] held;
      held = flagsOut;
      @(negedge clk);
      oldFlags = 8'(~held); flagMask = 8'hFF; dest = 64'(k);
      @(negedge clk);
      chkWord("R9 hold", flagsOut, held);
    end

    // Random mix
    for (int t = 0; t < 400; t++) begin
      logic [63:0] a, b, j;
      a = {$urandom, $urandom}; b = {$urandom, $urandom}; j = {$urandom, $urandom};
      if (t % 7 == 0) b = -a;
      runOp(8'($urandom), 8'($urandom), a, b, 2'($urandom), 1'($urandom), j);
      chkBits(flagsOut, expWord);
    end

    // R10: reset wins over valid mid-run
    runOp(8'hFF, 8'h00, 64'h1, 64'h1, 2'd0, 1'b0, '0);
    @(negedge clk);
    rst = 1'b1; valid = 1'b1;
    @(negedge clk);
    chkWord("R10 reset over valid", flagsOut, 8'h00);
    rst = 1'b0; valid = 1'b0;

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule